// File: doc/BRIEF.md
# Escape Opcode Queue Tracker

This block sits beside a host CPU and tracks which instruction the CPU is executing, so that a numeric coprocessor can pick out the instructions meant for it. Watching the bus is not enough to do this, because the CPU fetches bytes well before it executes them. The block therefore keeps its own copy of the CPU's instruction prefetch queue. Every fetched byte is written into that copy, and bytes are removed in step with the CPU's 2-bit queue status output.

When the CPU starts an instruction whose first byte carries the escape prefix, the block keeps that byte. It then waits for the next following byte of the same instruction. From the pair it forms a 6-bit coprocessor operation code and the addressing-mode fields, and it raises a one-cycle valid strobe.

A queue flush, either from the status code or from a dedicated input, empties the copy and drops any instruction that is half captured. A removal from an empty copy sets a sticky error flag, which only reset clears.

Top module: `esc_queue_tracker`

## Requirements
- R1: After reset, `op_valid` and `pop_err` are 0 and the queue copy is empty.
- R2: Each cycle with `fetch_valid` high appends `fetch_byte` to the queue copy. Bytes leave the copy in fetch order. A fetch and a removal in the same cycle both take effect, and the removal takes the byte at the head before that cycle's fetch.
- R3: The queue copy holds DEPTH bytes (6 by default). A fetch that arrives while the copy is full is discarded.
- R4: `qstat` encodes 00 as idle, 01 as the first byte of an instruction taken, 10 as a queue flush, and 11 as a later byte of the instruction taken. Codes 01 and 11 each remove one byte from the head.
- R5: An escape is recognised only when a byte is removed with code 01 and its bits [7:3] equal 11011.
- R6: After an escape, the next removal with code 11 completes the capture. `op_code` = {first[2:0], second[5:3]}, `mod_field` = second[7:6] and `rm_field` = second[2:0]. `op_valid` is high for exactly the one cycle that follows the clock edge of that removal, and the fields hold their values until the next capture.
- R7: A first byte without the escape prefix produces no strobe. A removal with code 11 that has no escape waiting produces no strobe.
- R8: A flush, given either by `qstat` = 10 or by `flush` high, empties the queue copy and abandons any waiting escape without a strobe. A fetch in the same cycle as a flush is dropped, and `flush` takes priority over any `qstat` code.
- R9: A removal (code 01 or 11) while the copy is empty sets `pop_err`. It leaves the queue and any waiting escape unchanged. `pop_err` stays set until reset, through flushes.
- R10: A new first-byte removal replaces any escape that is still waiting for its second byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A byte was fetched by the CPU this cycle |
| fetch_byte | input | 8 | The fetched byte |
| flush | input | 1 | Empties the queue copy |
| qstat | input | 2 | CPU queue status code |
| op_valid | output | 1 | One-cycle strobe for a captured coprocessor instruction |
| op_code | output | 6 | Coprocessor operation code |
| mod_field | output | 2 | Addressing-mode field of the second byte |
| rm_field | output | 3 | Register/memory field of the second byte |
| pop_err | output | 1 | Sticky flag for a removal from an empty queue copy |

## Verification
The hardest situations to reach from the ports are those where the queue state and the capture state interact. One is an escape that is still waiting when a flush arrives. Another is an escape that survives a removal from an empty queue. A third is a fetch that lands on a full copy, which is only visible from the ports through what is removed afterwards. The stimulus builds each of these on purpose. It fills the copy to its limit and then removes one byte more than was accepted, so the error flag shows that the extra byte was dropped. It also splits an escape and its second byte across a flush, and across an empty removal followed by a late fetch. Expected captures go into a scoreboard that the monitor drains on every strobe.

// File: rtl/esc_queue_tracker.sv
module esc_queue_tracker #(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_byte,
  input  logic       flush,
  input  logic [1:0] qstat,
  output logic       op_valid,
  output logic [5:0] op_code,
  output logic [1:0] mod_field,
  output logic [2:0] rm_field,
  output logic       pop_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [4:0] ESC = 5'b11011;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          pending;
  logic [2:0]    first_lo;

  wire clear    = flush || (qstat == 2'b10);
  wire take     = !flush && qstat[0];
  wire is_first = (qstat == 2'b01);
  wire empty    = (cnt == '0);
  wire full     = (cnt == CW'(DEPTH));
  wire do_pop   = take && !empty;
  wire do_push  = fetch_valid && !clear && !full;
  wire [7:0] head = mem[rd_ptr];

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= fetch_byte;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      first_lo  <= '0;
      op_valid  <= 1'b0;
      op_code   <= '0;
      mod_field <= '0;
      rm_field  <= '0;
      pop_err   <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      if (take && empty) pop_err <= 1'b1;
      if (clear) begin
        pending <= 1'b0;
      end else if (do_pop && is_first) begin
        pending  <= (head[7:3] == ESC);
        first_lo <= head[2:0];
      end else if (do_pop && pending) begin
        pending   <= 1'b0;
        op_valid  <= 1'b1;
        op_code   <= {first_lo, head[5:3]};
        mod_field <= head[7:6];
        rm_field  <= head[2:0];
      end
    end
  end
endmodule

// File: rtl/esc_queue_tracker_chk.sv
module esc_queue_tracker_chk #(
  parameter int DEPTH = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fetch_valid,
  input logic                       flush,
  input logic [1:0]                 qstat,
  input logic                       op_valid,
  input logic                       pop_err,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  p_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));

  p_after_later_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ($past(qstat) == 2'b11 && !$past(flush)));

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || qstat == 2'b10) |=> (!op_valid && cnt == '0));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && qstat[0] && cnt == '0) |=> pop_err);

  p_empty_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && qstat[0] && cnt == '0 && !fetch_valid) |=> (cnt == '0 && !op_valid));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_err |=> pop_err);
endmodule

bind esc_queue_tracker esc_queue_tracker_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .flush(flush),
  .qstat(qstat), .op_valid(op_valid), .pop_err(pop_err), .cnt(cnt)
);

// File: tb/esc_queue_tracker_tb_top.sv
module esc_queue_tracker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_byte = '0;
  logic       flush = 1'b0;
  logic [1:0] qstat = 2'b00;
  logic       op_valid, pop_err;
  logic [5:0] op_code;
  logic [1:0] mod_field;
  logic [2:0] rm_field;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_q[$];

  esc_queue_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .flush(flush), .qstat(qstat), .op_valid(op_valid), .op_code(op_code),
    .mod_field(mod_field), .rm_field(rm_field), .pop_err(pop_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input logic fv, input logic [7:0] fb, input logic [1:0] qs, input logic fl);
    fetch_valid = fv; fetch_byte = fb; qstat = qs; flush = fl;
    @(negedge clk);
    fetch_valid = 1'b0; qstat = 2'b00; flush = 1'b0;
  endtask

  task automatic fetch(input logic [7:0] b);
    cyc(1'b1, b, 2'b00, 1'b0);
  endtask

  task automatic expect_op(input logic [5:0] op, input logic [1:0] md, input logic [2:0] rm);
    exp_q.push_back({op, md, rm});
  endtask

  task automatic check_err(input logic exp, input string tag);
    checks++;
    if (pop_err !== exp) begin
      errors++;
      $display("FAIL %s pop_err actual=%0b expected=%0b", tag, pop_err, exp);
    end
  endtask

  task automatic check_drained(input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s pending captures actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected strobe actual=%h_%h_%h expected=none",
                 op_code, mod_field, rm_field);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if ({op_code, mod_field, rm_field} !== e) begin
          errors++;
          $display("FAIL R6 capture actual=%b_%b_%b expected=%b_%b_%b",
                   op_code, mod_field, rm_field, e[10:5], e[4:3], e[2:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (op_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 op_valid actual=%b expected=0", op_valid);
    end
    check_err(1'b0, "R1");

    // R5 R6 basic escape capture: D9 E8 -> 001101 / 11 / 000
    fetch(8'hD9); fetch(8'hE8);
    expect_op(6'b001101, 2'b11, 3'b000);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R6");

    // R7 non-escape instruction gives no strobe
    fetch(8'h90); fetch(8'h8B);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    cyc(0, 0, 2'b00, 0);
    check_err(1'b0, "R7");
    check_drained("R7");

    // R2 fetch and pop in the same cycle
    fetch(8'hD9);
    expect_op(6'b001101, 2'b11, 3'b000);
    cyc(1, 8'hE8, 2'b01, 0);
    cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R2");
    check_err(1'b0, "R2");

    // R3 fill to depth, seventh fetch dropped
    fetch(8'hDC); fetch(8'hC1); fetch(8'hD8); fetch(8'h05); fetch(8'h11); fetch(8'h22);
    fetch(8'h33);
    expect_op(6'b100000, 2'b11, 3'b001);
    expect_op(6'b000000, 2'b00, 3'b101);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R3");
    check_err(1'b0, "R3");
    cyc(0, 0, 2'b01, 0);
    check_err(1'b1, "R3");

    // R8 status flush abandons a waiting escape and empties the copy
    do_reset();
    check_err(1'b0, "R1");
    fetch(8'hDB); fetch(8'h2E); fetch(8'hDA);
    cyc(0, 0, 2'b01, 0);
    cyc(0, 0, 2'b10, 0);
    cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R8");
    check_err(1'b1, "R8");

    // R9 sticky through flush, cleared by reset
    cyc(0, 0, 2'b10, 0); cyc(0, 0, 2'b00, 1);
    check_err(1'b1, "R9");
    do_reset();
    check_err(1'b0, "R9");

    // R8 flush pin drops a same-cycle fetch
    fetch(8'hD8);
    cyc(0, 0, 2'b01, 0);
    cyc(1, 8'hD9, 2'b00, 1);
    cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R8");
    check_err(1'b1, "R8");
    do_reset();

    // R10 second first-byte replaces a waiting escape: D8 D9 C9 -> 001001 / 11 / 001
    fetch(8'hD8); fetch(8'hD9); fetch(8'hC9);
    expect_op(6'b001001, 2'b11, 3'b001);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R10");

    // R9 empty pop keeps the waiting escape: DF, empty pop, then E0 -> 111100 / 11 / 000
    fetch(8'hDF);
    cyc(0, 0, 2'b01, 0);
    cyc(0, 0, 2'b11, 0);
    check_err(1'b1, "R9");
    fetch(8'hE0);
    expect_op(6'b111100, 2'b11, 3'b000);
    cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R9");

    // R4 idle code leaves the queue alone; R6 fields hold
    fetch(8'hDD); fetch(8'h46);
    cyc(0, 0, 2'b00, 0); cyc(0, 0, 2'b00, 0);
    checks++;
    if ({op_code, mod_field, rm_field} !== {6'b111100, 2'b11, 3'b000}) begin
      errors++;
      $display("FAIL R6 held fields actual=%b expected=%b",
               {op_code, mod_field, rm_field}, {6'b111100, 2'b11, 3'b000});
    end
    expect_op(6'b101000, 2'b01, 3'b110);
    cyc(0, 0, 2'b01, 0); cyc(0, 0, 2'b11, 0);
    @(negedge clk);
    check_drained("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule